// File: doc/BRIEF.md
# Timer Counter Slave Mode Controller

This block is a 16-bit up/down counter whose stepping source is chosen by a 3-bit slave-mode field. Depending on the mode, the counter runs on the system clock, follows a two-channel quadrature encoder, is reloaded or gated by a trigger input, waits for a trigger before it starts, or counts trigger rising edges as an external clock.

The encoder channels and the trigger arrive already filtered and synchronous to the system clock. Each input is compared with a one-cycle delayed copy to find its edges. The counter takes at most one step per clock.

When counting up, the counter wraps to zero after the auto-reload value. When counting down, it wraps from zero back to the auto-reload value. Each wrap, and each trigger reload, gives a one-cycle update pulse. A separate one-cycle flag marks trigger rising edges seen in the trigger-driven modes.

Top module: `tmr_slave_ctl`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, `dir_down` is 0, `update` is 0 and `trig_evt` is 0. The delayed input copies also reset to 0.
- R2: While `enable` is 0, `count` holds and `update` stays 0. The trigger-start running flag clears.
- R3: Mode 0 (`slv_mode`=3'd0): with `enable` high, the counter adds one on every clock.
- R4: Mode 1: the counter steps only when channel B changes. It counts up when the new B level equals the A level, and down otherwise.
- R5: Mode 2: the counter steps only when channel A changes. It counts up when the new A level differs from the B level, and down otherwise.
- R6: Mode 3: a change on exactly one channel steps the counter, using the R4 rule for B and the R5 rule for A. A change on both channels in the same clock gives no step.
- R7: A down step from 0 loads `arr` and pulses `update` for one cycle. In modes 1 to 3, `dir_down` holds the direction of the last step (1 = down). In every other mode it reads 0.
- R8: Mode 4: a rising edge on `trig_in` loads 0 and pulses `update`. Without that edge, the counter counts up on every clock.
- R9: Mode 5: the counter adds one on each clock in which `trig_in` is high.
- R10: Mode 6: the counter is stopped until a rising edge on `trig_in`. It then adds one on every clock from the following clock on, whatever `trig_in` does. Only reset or `enable` low stops it again.
- R11: Mode 7: the counter adds one for each rising edge of `trig_in`.
- R12: `trig_evt` pulses for one cycle after a `trig_in` rising edge seen with `enable` high in modes 4 to 7, and stays 0 otherwise.
- R13: An up step taken when `count` is greater than or equal to `arr` loads 0 and pulses `update`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slv_mode | input | 3 | Slave-mode select, 0 to 7 |
| enc_a | input | 1 | Filtered encoder channel A |
| enc_b | input | 1 | Filtered encoder channel B |
| trig_in | input | 1 | Selected trigger input |
| arr | input | 16 | Auto-reload value |
| enable | input | 1 | Counter enable |
| count | output | 16 | Counter value |
| dir_down | output | 1 | Direction of the last encoder step, 1 = down |
| update | output | 1 | One-cycle pulse on a wrap or a trigger reload |
| trig_evt | output | 1 | One-cycle pulse after an accepted trigger rising edge |

## Verification
All results are due exactly one clock after the edge at which their inputs are sampled. Edge detection works on the raw input against the copy taken at the previous edge, so a change driven before edge k moves `count`, `dir_down`, `update` and `trig_evt` at edge k. The one exception is the trigger-start mode: there the edge at k only sets the running flag, and counting is first visible after edge k+1. The bench drives inputs on the falling edge, advances its model once per rising edge, and compares one time unit after that rising edge.

// File: rtl/tsc_pkg.sv
// Package: shared mode encoding and step request type for the slave
// mode controller. Assumes a 3-bit mode field.
package tsc_pkg;

    typedef enum logic [2:0] {
        TSC_FREE    = 3'd0,
        TSC_ENC_B   = 3'd1,
        TSC_ENC_A   = 3'd2,
        TSC_ENC_AB  = 3'd3,
        TSC_RELOAD  = 3'd4,
        TSC_GATED   = 3'd5,
        TSC_START   = 3'd6,
        TSC_EXTCLK  = 3'd7
    } tsc_mode_e;

    typedef struct packed {
        logic up;
        logic down;
        logic reload;
    } tsc_step_t;

endpackage

// File: rtl/tsc_edge.sv
// Module: tsc_edge
// Keeps a one-cycle delayed copy of each input bit and reports change and
// rising-edge strobes for the current cycle. Assumes inputs are already
// synchronous to clk. The delayed copies reset to 0.
module tsc_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] chg,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Delay each input bit by one clock.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig[i];
        end
        assign chg[i]  = sig[i] ^ prev_q[i];
        assign rise[i] = sig[i] & ~prev_q[i];
    end

endmodule

// File: rtl/tsc_step_dec.sv
// Module: tsc_step_dec
// Turns the mode, the enable bit and the edge strobes into one step request
// per clock (up, down or reload). Holds the trigger-start running flag and
// produces the registered trigger-event flag. Assumes the edge strobes
// belong to the current cycle.
module tsc_step_dec
    import tsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tsc_mode_e mode,
    input  logic      enable,
    input  logic      lvl_a,
    input  logic      lvl_b,
    input  logic      chg_a,
    input  logic      chg_b,
    input  logic      trig_lvl,
    input  logic      trig_rise,
    output tsc_step_t step,
    output logic      enc_mode,
    output logic      trig_evt
);
    logic run_q;
    logic a_up;
    logic b_up;

    // Quadrature rule: A leading B counts up, B leading A counts down.
    assign a_up = lvl_a ^ lvl_b;
    assign b_up = ~(lvl_a ^ lvl_b);
    assign enc_mode = (mode == TSC_ENC_B) || (mode == TSC_ENC_A) || (mode == TSC_ENC_AB);

    // Choose the step request for this cycle from the active mode.
    always_comb begin
        step = '0;
        if (enable) begin
            unique case (mode)
                TSC_FREE:   step.up = 1'b1;
                TSC_ENC_B: begin
                    step.up   = chg_b & b_up;
                    step.down = chg_b & ~b_up;
                end
                TSC_ENC_A: begin
                    step.up   = chg_a & a_up;
                    step.down = chg_a & ~a_up;
                end
                TSC_ENC_AB: begin
                    if (chg_a && !chg_b) begin
                        step.up   = a_up;
                        step.down = ~a_up;
                    end else if (chg_b && !chg_a) begin
                        step.up   = b_up;
                        step.down = ~b_up;
                    end
                end
                TSC_RELOAD: begin
                    step.reload = trig_rise;
                    step.up     = ~trig_rise;
                end
                TSC_GATED:  step.up = trig_lvl;
                TSC_START:  step.up = run_q;
                TSC_EXTCLK: step.up = trig_rise;
                default:    step = '0;
            endcase
        end
    end

    // Running flag of trigger-start mode; cleared only by reset or enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (!enable) run_q <= 1'b0;
        else if (mode == TSC_START && trig_rise) run_q <= 1'b1;
    end

    // One-cycle flag for trigger rising edges in the trigger-driven modes.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_evt <= 1'b0;
        else        trig_evt <= enable & trig_rise & mode[2];
    end

    a_r6_single_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(step.up && step.down));

    a_r10_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && enable) |=> run_q);

    a_r2_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !run_q);

endmodule

// File: rtl/tsc_counter.sv
// Module: tsc_counter
// Counter register with auto-reload wrap in both directions, update pulse
// and direction register. Assumes at most one of up/down is requested;
// a reload overrides both.
module tsc_counter
    import tsc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tsc_step_t    step,
    input  logic         enc_mode,
    input  logic [W-1:0] arr,
    output logic [W-1:0] count,
    output logic         dir_down,
    output logic         update
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_nxt;
    logic         wrap_nxt;

    // Next count value and wrap flag.
    always_comb begin
        cnt_nxt  = count;
        wrap_nxt = 1'b0;
        if (step.reload) begin
            cnt_nxt  = ZERO;
            wrap_nxt = 1'b1;
        end else if (step.up) begin
            if (count >= arr) begin
                cnt_nxt  = ZERO;
                wrap_nxt = 1'b1;
            end else begin
                cnt_nxt = count + ONE;
            end
        end else if (step.down) begin
            if (count == ZERO) begin
                cnt_nxt  = arr;
                wrap_nxt = 1'b1;
            end else begin
                cnt_nxt = count - ONE;
            end
        end
    end

    // Register the count and the update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= ZERO;
            update <= 1'b0;
        end else begin
            count  <= cnt_nxt;
            update <= wrap_nxt;
        end
    end

    // Track the last encoder step direction; reads up outside encoder modes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_down <= 1'b0;
        else if (!enc_mode)                dir_down <= 1'b0;
        else if (step.up || step.down)     dir_down <= step.down;
    end

    a_r13_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step.up && !step.reload && count >= arr) |=> (count == ZERO && update));

    a_r7_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step.down && !step.up && !step.reload && count == ZERO)
        |=> (count == $past(arr) && update));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(step.up || step.down || step.reload) |=> ($stable(count) && !update));

endmodule

// File: rtl/tmr_slave_ctl.sv
// Module: tmr_slave_ctl (top)
// Timer counter with a 3-bit slave-mode select: free run, three quadrature
// encoder modes, trigger reload, gated, trigger start and external clock.
// Assumes encoder channels and trigger are filtered and synchronous to clk.
module tmr_slave_ctl
    import tsc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       slv_mode,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] arr,
    input  logic             enable,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             update,
    output logic             trig_evt
);
    localparam int NIN = 3;

    logic [NIN-1:0] in_vec;
    logic [NIN-1:0] in_chg;
    logic [NIN-1:0] in_rise;
    tsc_step_t      step;
    logic           enc_mode;
    tsc_mode_e      mode;

    assign in_vec = {trig_in, enc_b, enc_a};
    assign mode   = tsc_mode_e'(slv_mode);

    tsc_edge #(.N(NIN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (in_vec),
        .chg  (in_chg),
        .rise (in_rise)
    );

    tsc_step_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .enable   (enable),
        .lvl_a    (enc_a),
        .lvl_b    (enc_b),
        .chg_a    (in_chg[0]),
        .chg_b    (in_chg[1]),
        .trig_lvl (trig_in),
        .trig_rise(in_rise[2]),
        .step     (step),
        .enc_mode (enc_mode),
        .trig_evt (trig_evt)
    );

    tsc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .enc_mode(enc_mode),
        .arr     (arr),
        .count   (count),
        .dir_down(dir_down),
        .update  (update)
    );

    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(count) && !update));

    a_r8_trig_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slv_mode == 3'd4 && in_rise[2]) |=> (count == '0 && update));

    a_r12_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |-> ($past(trig_in) && $past(enable) && $past(slv_mode[2])));

endmodule

// File: tb/tmr_slave_ctl_test.sv
module tmr_slave_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  slv_mode;
    logic        enc_a, enc_b, trig_in, enable;
    logic [15:0] arr;
    logic [15:0] count;
    logic        dir_down, update, trig_evt;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [15:0] m_cnt;
    logic m_dir, m_upd, m_evt, m_run, m_pa, m_pb, m_pt;

    always #5 clk = ~clk;

    tmr_slave_ctl uut (
        .clk(clk), .rst_n(rst_n), .slv_mode(slv_mode), .enc_a(enc_a),
        .enc_b(enc_b), .trig_in(trig_in), .arr(arr), .enable(enable),
        .count(count), .dir_down(dir_down), .update(update), .trig_evt(trig_evt)
    );

    function automatic string mode_tag(input logic [2:0] m, input logic en);
        if (!en) return "R2";
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model by one rising edge using the driven inputs.
    task automatic model_step();
        logic ca, cb, rt, up, dn, rl;
        if (!rst_n) begin
            m_cnt = 0; m_dir = 0; m_upd = 0; m_evt = 0; m_run = 0;
            m_pa = 0; m_pb = 0; m_pt = 0;
            return;
        end
        ca = enc_a ^ m_pa; cb = enc_b ^ m_pb; rt = trig_in & ~m_pt;
        up = 0; dn = 0; rl = 0;
        if (enable) begin
            case (slv_mode)
                3'd0: up = 1;
                3'd1: if (cb) begin up = (enc_b == enc_a); dn = !up; end
                3'd2: if (ca) begin up = (enc_a != enc_b); dn = !up; end
                3'd3: begin
                    if (ca && !cb) begin up = (enc_a != enc_b); dn = !up; end
                    else if (cb && !ca) begin up = (enc_b == enc_a); dn = !up; end
                end
                3'd4: begin rl = rt; up = !rt; end
                3'd5: up = trig_in;
                3'd6: up = m_run;
                default: up = rt;
            endcase
        end
        m_upd = 0;
        if (rl) begin m_cnt = 0; m_upd = 1; end
        else if (up) begin
            if (m_cnt >= arr) begin m_cnt = 0; m_upd = 1; end else m_cnt = m_cnt + 1;
        end else if (dn) begin
            if (m_cnt == 0) begin m_cnt = arr; m_upd = 1; end else m_cnt = m_cnt - 1;
        end
        if (slv_mode inside {3'd1, 3'd2, 3'd3}) begin
            if (up || dn) m_dir = dn;
        end else m_dir = 0;
        if (!enable) m_run = 0;
        else if (slv_mode == 3'd6 && rt) m_run = 1;
        m_evt = enable & rt & slv_mode[2];
        m_pa = enc_a; m_pb = enc_b; m_pt = trig_in;
    endtask

    // Drive one cycle at the falling edge, compare after the rising edge.
    task automatic cyc(input logic [2:0] m, input logic a, input logic b,
                       input logic t, input logic en, input logic [15:0] r);
        string tag;
        @(negedge clk);
        slv_mode = m; enc_a = a; enc_b = b; trig_in = t; enable = en; arr = r;
        tag = mode_tag(m, en);
        @(posedge clk);
        model_step();
        #1;
        if (!rst_n) tag = "R1";
        chk(tag, "count", count, m_cnt);
        chk((m_upd && !rst_n) ? "R1" : "R7/R13", "update", update, m_upd);
        chk(rst_n ? "R7" : "R1", "dir_down", dir_down, m_dir);
        chk(rst_n ? "R12" : "R1", "trig_evt", trig_evt, m_evt);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a, b, t, en;
        logic [2:0] m;
        logic [15:0] r;
        void'($urandom(32'd1234));
        rst_n = 0;
        cyc(3'd0, 0, 0, 0, 1, 16'd5);            // R1 reset state
        cyc(3'd0, 1, 1, 1, 1, 16'd5);
        rst_n = 1;
        // R3 free run with wrap at arr=3
        for (int i = 0; i < 9; i++) cyc(3'd0, 0, 0, 0, 1, 16'd3);
        // R2 disable holds
        for (int i = 0; i < 3; i++) cyc(3'd0, 0, 0, 0, 0, 16'd3);
        // R13 count above arr wraps
        for (int i = 0; i < 10; i++) cyc(3'd0, 0, 0, 0, 1, 16'd100);
        cyc(3'd0, 0, 0, 0, 1, 16'd4);
        // R4 mode 1 forward then reverse quadrature; R7 down wrap
        cyc(3'd1, 1, 0, 0, 1, 16'd7); cyc(3'd1, 1, 1, 0, 1, 16'd7);
        cyc(3'd1, 0, 1, 0, 1, 16'd7); cyc(3'd1, 0, 0, 0, 1, 16'd7);
        for (int i = 0; i < 3; i++) begin
            cyc(3'd1, 0, 1, 0, 1, 16'd7); cyc(3'd1, 1, 1, 0, 1, 16'd7);
            cyc(3'd1, 1, 0, 0, 1, 16'd7); cyc(3'd1, 0, 0, 0, 1, 16'd7);
        end
        // R5 mode 2
        cyc(3'd2, 1, 0, 0, 1, 16'd7); cyc(3'd2, 1, 1, 0, 1, 16'd7);
        cyc(3'd2, 0, 1, 0, 1, 16'd7); cyc(3'd2, 0, 0, 0, 1, 16'd7);
        // R6 mode 3 including simultaneous change
        cyc(3'd3, 1, 0, 0, 1, 16'd7); cyc(3'd3, 1, 1, 0, 1, 16'd7);
        cyc(3'd3, 0, 0, 0, 1, 16'd7); cyc(3'd3, 0, 1, 0, 1, 16'd7);
        // R8 reload on trigger rise
        for (int i = 0; i < 4; i++) cyc(3'd4, 0, 0, 0, 1, 16'd50);
        cyc(3'd4, 0, 0, 1, 1, 16'd50); cyc(3'd4, 0, 0, 1, 1, 16'd50);
        // R9 gated
        for (int i = 0; i < 6; i++) cyc(3'd5, 0, 0, i[1], 1, 16'd50);
        // R10 trigger start, keeps running after trigger falls, stops on enable low
        cyc(3'd6, 0, 0, 0, 1, 16'd50); cyc(3'd6, 0, 0, 0, 1, 16'd50);
        cyc(3'd6, 0, 0, 1, 1, 16'd50);
        for (int i = 0; i < 4; i++) cyc(3'd6, 0, 0, 0, 1, 16'd50);
        cyc(3'd6, 0, 0, 0, 0, 16'd50);
        cyc(3'd6, 0, 0, 0, 1, 16'd50); cyc(3'd6, 0, 0, 0, 1, 16'd50);
        // R11 external clock
        for (int i = 0; i < 8; i++) cyc(3'd7, 0, 0, i[0], 1, 16'd50);
        // R12 trigger edge in mode 0 gives no event
        cyc(3'd0, 0, 0, 1, 1, 16'd50); cyc(3'd0, 0, 0, 0, 1, 16'd50);
        // Random phase
        a = 0; b = 0; t = 0; m = 0; r = 16'd9; en = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) begin
                m = 3'($urandom_range(0, 7));
                r = 16'($urandom_range(0, 20));
            end
            en = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 5))
                0: a = ~a;
                1: b = ~b;
                2: begin a = ~a; b = ~b; end
                default: ;
            endcase
            if ($urandom_range(0, 2) == 0) t = ~t;
            cyc(m, a, b, t, en, r);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule